// File: doc/BRIEF.md
# Secondary-CPU Boot Vector Overlay

This unit sits between a secondary processor and its boot ROM. While the overlay is active, it replaces the first 32 bytes of the secondary processor's address space, which hold its exception vector table, with a small code window. A host processor fills that window and sets a one-byte personality register through a simple write port. The host then releases the secondary processor from reset by writing a fixed start word. The secondary processor therefore fetches its reset vector, and the rest of the vector table, from code that the host supplied.

When the secondary processor has finished with the host-supplied vectors, it writes its own protection register to turn the overlay off. From then on, every fetch reaches the boot ROM. After release the host can no longer change the window or the mode. Only a full system reset restores the overlay. The fetch path has no added latency, because the window is held in flops and selected combinationally.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: After reset, `cpu_rst_n` is 0, `ovl_active` is 1, `mode_byte` is 0, `personality` is 0 and `uninit_fetch` is 0.
- R2: A host write to word offset 0 with `host_be[0]` set loads `host_wdata[7:0]` into `mode_byte`. `personality` is 2'b01 when the mode is 1, 2'b10 when it is 2, and 2'b00 otherwise.
- R3: `cpu_rst_n` goes to 1 in the cycle after a host write to word offset 1 with `host_be[1:0]` = 2'b11 and `host_wdata[15:0]` = 16'h8001. A write of any other value to that offset leaves `cpu_rst_n` at 0.
- R4: Once `cpu_rst_n` is 1, it stays 1 until `rst_n` is asserted.
- R5: A host write to word offset 8+k (k = 0..7) stores each byte lane of `host_wdata` whose `host_be` bit is set into window word k. The other lanes keep their old contents.
- R6: While `ovl_active` is 1, a fetch at a byte address below 32 returns window word `fetch_addr[4:2]` in the same cycle.
- R7: A fetch at a byte address of 32 or above always returns `rom_rdata`.
- R8: After release, host writes to the mode register and to the window have no effect.
- R9: A secondary-side protection write (`sec_prot_wr`) with `sec_prot_wdata[0]` = 1 clears `ovl_active` from the next cycle. After that, fetches at addresses 0 to 31 return `rom_rdata`.
- R10: A protection write with bit 0 = 0 neither disables nor re-enables the overlay. Only `rst_n` brings the overlay back.
- R11: While the overlay is active, a fetch with `fetch_en` = 1 of a window word that no host write with a nonzero byte enable has touched returns 0. Such a fetch sets `uninit_fetch` from the next cycle, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 5 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte enables |
| mode_byte | output | 8 | Current mode register |
| personality | output | 2 | Decoded personality (bit 0: mode 1, bit 1: mode 2) |
| cpu_rst_n | output | 1 | Reset release for the secondary CPU |
| sec_prot_wr | input | 1 | Secondary-side protection register write strobe |
| sec_prot_wdata | input | 8 | Protection write data; bit 0 disables the overlay |
| fetch_en | input | 1 | Secondary fetch valid |
| fetch_addr | input | 16 | Secondary fetch byte address |
| rom_rdata | input | 32 | Underlying boot ROM data |
| fetch_rdata | output | 32 | Data returned to the secondary CPU |
| ovl_active | output | 1 | Overlay currently enabled |
| uninit_fetch | output | 1 | Sticky flag for a fetch of an unwritten window word |

## Verification
The bench builds the block with its defaults: eight window words, a 5-bit host offset and a 16-bit fetch address. With these values it can write every window word and every byte-enable pattern, and it can fetch each 32-byte boundary from both sides, from address 31 across to address 32. The 16-bit fetch address also lets random fetches reach addresses far above the window, so the ROM path is exercised well outside the overlay range. A fixed-seed random phase runs before and after release, and directed cases cover the start word, the protection writes and the reset return.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BE_W       = DATA_W / 8;
    localparam int unsigned OFS_MODE   = 0;
    localparam int unsigned OFS_START  = 1;
    localparam int unsigned OFS_WIN    = 8;
    localparam logic [15:0] GO_WORD    = 16'h8001;
endpackage

// File: rtl/ovl_host_regs.sv
module ovl_host_regs
    import boot_ovl_pkg::*;
#(
    parameter int unsigned WIN_WORDS = 8,
    parameter int unsigned HOST_AW   = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_wr_en,
    input  logic [HOST_AW-1:0]                 host_addr,
    input  logic [DATA_W-1:0]                  host_wdata,
    input  logic [BE_W-1:0]                    host_be,
    output logic [7:0]                         mode_o,
    output logic                               released_o,
    output logic [WIN_WORDS-1:0][DATA_W-1:0]   win_o,
    output logic [WIN_WORDS-1:0]               written_o
);
    typedef struct packed {
        logic [7:0]                       mode;
        logic                             released;
        logic [WIN_WORDS-1:0]             written;
        logic [WIN_WORDS-1:0][DATA_W-1:0] win;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (host_wr_en && !q.released) begin
            if (host_addr == HOST_AW'(OFS_MODE) && host_be[0]) begin
                d.mode = host_wdata[7:0];
            end
            if (host_addr == HOST_AW'(OFS_START) && host_be[1:0] == 2'b11
                && host_wdata[15:0] == GO_WORD) begin
                d.released = 1'b1;
            end
            for (int i = 0; i < WIN_WORDS; i++) begin
                if (host_addr == HOST_AW'(OFS_WIN + i)) begin
                    for (int b = 0; b < BE_W; b++) begin
                        if (host_be[b]) begin
                            d.win[i][b*8 +: 8] = host_wdata[b*8 +: 8];
                        end
                    end
                    if (|host_be) begin
                        d.written[i] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode_o     = q.mode;
    assign released_o = q.released;
    assign win_o      = q.win;
    assign written_o  = q.written;

    // R4
    release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.released |=> q.released);

    // R8
    frozen_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.released |=> ($stable(q.win) && $stable(q.mode) && $stable(q.written)));

    // R3
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.released && !d.released |=> !q.released);
endmodule

// File: rtl/ovl_fetch_mux.sv
module ovl_fetch_mux
    import boot_ovl_pkg::*;
#(
    parameter int unsigned WIN_WORDS = 8,
    parameter int unsigned FETCH_AW  = 16
) (
    input  logic                             fetch_en,
    input  logic [FETCH_AW-1:0]              fetch_addr,
    input  logic [DATA_W-1:0]                rom_rdata,
    input  logic                             ovl_on,
    input  logic [WIN_WORDS-1:0][DATA_W-1:0] win,
    input  logic [WIN_WORDS-1:0]             written,
    output logic [DATA_W-1:0]                fetch_rdata,
    output logic                             uninit_hit
);
    localparam int unsigned WIN_BYTES = WIN_WORDS * BE_W;
    localparam int unsigned IDX_W     = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;

    logic             in_win;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_win      = (fetch_addr < FETCH_AW'(WIN_BYTES));
        idx         = fetch_addr[2 +: IDX_W];
        fetch_rdata = rom_rdata;
        uninit_hit  = 1'b0;
        if (ovl_on && in_win) begin
            if (written[idx]) begin
                fetch_rdata = win[idx];
            end else begin
                fetch_rdata = '0;
                uninit_hit  = fetch_en;
            end
        end
    end
endmodule

// File: rtl/ovl_guard.sv
module ovl_guard (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_prot_wr,
    input  logic [7:0] sec_prot_wdata,
    input  logic       uninit_hit,
    output logic       disabled_o,
    output logic       uninit_o
);
    typedef struct packed {
        logic disabled;
        logic uninit;
    } guard_t;

    guard_t d, q;

    always_comb begin
        d = q;
        if (sec_prot_wr && sec_prot_wdata[0]) begin
            d.disabled = 1'b1;
        end
        if (uninit_hit) begin
            d.uninit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign disabled_o = q.disabled;
    assign uninit_o   = q.uninit;

    // R10
    disable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.disabled |=> q.disabled);

    // R9
    disable_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_prot_wr && sec_prot_wdata[0]) |=> q.disabled);

    // R11
    uninit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.uninit |=> q.uninit);
endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
    import boot_ovl_pkg::*;
#(
    parameter int unsigned WIN_WORDS = 8,
    parameter int unsigned HOST_AW   = 5,
    parameter int unsigned FETCH_AW  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr_en,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [31:0]         host_wdata,
    input  logic [3:0]          host_be,
    output logic [7:0]          mode_byte,
    output logic [1:0]          personality,
    output logic                cpu_rst_n,
    input  logic                sec_prot_wr,
    input  logic [7:0]          sec_prot_wdata,
    input  logic                fetch_en,
    input  logic [FETCH_AW-1:0] fetch_addr,
    input  logic [31:0]         rom_rdata,
    output logic [31:0]         fetch_rdata,
    output logic                ovl_active,
    output logic                uninit_fetch
);
    logic [WIN_WORDS-1:0][DATA_W-1:0] win;
    logic [WIN_WORDS-1:0]             written;
    logic                             released;
    logic                             disabled;
    logic                             uninit_hit;

    ovl_host_regs #(.WIN_WORDS(WIN_WORDS), .HOST_AW(HOST_AW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_be    (host_be),
        .mode_o     (mode_byte),
        .released_o (released),
        .win_o      (win),
        .written_o  (written)
    );

    ovl_fetch_mux #(.WIN_WORDS(WIN_WORDS), .FETCH_AW(FETCH_AW)) mux_i (
        .fetch_en    (fetch_en),
        .fetch_addr  (fetch_addr),
        .rom_rdata   (rom_rdata),
        .ovl_on      (!disabled),
        .win         (win),
        .written     (written),
        .fetch_rdata (fetch_rdata),
        .uninit_hit  (uninit_hit)
    );

    ovl_guard guard_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sec_prot_wr    (sec_prot_wr),
        .sec_prot_wdata (sec_prot_wdata),
        .uninit_hit     (uninit_hit),
        .disabled_o     (disabled),
        .uninit_o       (uninit_fetch)
    );

    always_comb begin
        personality = 2'b00;
        if (mode_byte == 8'd1) personality = 2'b01;
        if (mode_byte == 8'd2) personality = 2'b10;
    end

    assign cpu_rst_n  = released;
    assign ovl_active = !disabled;

    // R9
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_active |-> fetch_rdata == rom_rdata);

    // R7
    high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr >= FETCH_AW'(WIN_WORDS * 4)) |-> fetch_rdata == rom_rdata);

    // R11
    uninit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uninit_hit |=> uninit_fetch);
endmodule

// File: tb/boot_overlay_ctrl_tb_top.sv
module boot_overlay_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic [7:0]  mode_byte;
    logic [1:0]  personality;
    logic        cpu_rst_n;
    logic        sec_prot_wr = 1'b0;
    logic [7:0]  sec_prot_wdata = '0;
    logic        fetch_en = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [31:0] rom_rdata = '0;
    logic [31:0] fetch_rdata;
    logic        ovl_active;
    logic        uninit_fetch;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_win [8];
    logic        m_wr  [8];
    logic [7:0]  m_mode;
    logic        m_rel, m_dis, m_uninit;

    always #2.5 clk = ~clk;

    boot_overlay_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be), .mode_byte(mode_byte),
        .personality(personality), .cpu_rst_n(cpu_rst_n), .sec_prot_wr(sec_prot_wr),
        .sec_prot_wdata(sec_prot_wdata), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .rom_rdata(rom_rdata), .fetch_rdata(fetch_rdata), .ovl_active(ovl_active),
        .uninit_fetch(uninit_fetch)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pers(logic [7:0] m);
        return (m == 8'd1) ? 2'b01 : (m == 8'd2) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [31:0] exp_fetch(logic [15:0] a, logic [31:0] rom);
        if (!m_dis && a < 16'd32) return m_wr[a[4:2]] ? m_win[a[4:2]] : 32'h0;
        return rom;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_win[i] = '0; m_wr[i] = 1'b0; end
        m_mode = '0; m_rel = 1'b0; m_dis = 1'b0; m_uninit = 1'b0;
    endtask

    task automatic host_write(logic [4:0] a, logic [31:0] dat, logic [3:0] be);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = dat; host_be = be;
        @(negedge clk);
        host_wr_en = 1'b0; host_be = '0;
        if (!m_rel) begin
            if (a == 5'd0 && be[0]) m_mode = dat[7:0];
            if (a == 5'd1 && be[1:0] == 2'b11 && dat[15:0] == 16'h8001) m_rel = 1'b1;
            if (a >= 5'd8 && a <= 5'd15) begin
                for (int b = 0; b < 4; b++)
                    if (be[b]) m_win[a - 5'd8][b*8 +: 8] = dat[b*8 +: 8];
                if (be != 4'b0) m_wr[a - 5'd8] = 1'b1;
            end
        end
    endtask

    task automatic prot_write(logic [7:0] v);
        @(negedge clk);
        sec_prot_wr = 1'b1; sec_prot_wdata = v;
        @(negedge clk);
        sec_prot_wr = 1'b0;
        if (v[0]) m_dis = 1'b1;
    endtask

    task automatic fetch_check(string req, logic [15:0] a);
        logic [31:0] rom;
        @(negedge clk);
        rom = $urandom;
        fetch_en = 1'b1; fetch_addr = a; rom_rdata = rom;
        #1;
        check(req, fetch_rdata, exp_fetch(a, rom));
        if (!m_dis && a < 16'd32 && !m_wr[a[4:2]]) m_uninit = 1'b1;
        @(negedge clk);
        fetch_en = 1'b0;
        check("R11 flag", {31'b0, uninit_fetch}, {31'b0, m_uninit});
    endtask

    task automatic check_state(string req);
        check({req, " rst"}, {31'b0, cpu_rst_n}, {31'b0, m_rel});
        check({req, " ovl"}, {31'b0, ovl_active}, {31'b0, !m_dis});
        check({req, " mode"}, {24'b0, mode_byte}, {24'b0, m_mode});
        check({req, " pers"}, {30'b0, personality}, {30'b0, exp_pers(m_mode)});
        check({req, " uninit"}, {31'b0, uninit_fetch}, {31'b0, m_uninit});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1357);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R11: unwritten word returns zero and latches the flag
        fetch_check("R11 data", 16'd12);
        // R2: mode decode
        host_write(5'd0, 32'h0000_0002, 4'b0001); check_state("R2");
        host_write(5'd0, 32'hFFFF_FF01, 4'b0001); check_state("R2");
        host_write(5'd0, 32'h0000_0007, 4'b0000); check_state("R2");
        // R5: fill words, then partial byte lanes
        for (int i = 0; i < 8; i++) host_write(5'(8 + i), $urandom, 4'b1111);
        for (int i = 0; i < 40; i++) host_write(5'(8 + $urandom % 8), $urandom, 4'($urandom));
        // R3: wrong start values keep reset
        host_write(5'd1, 32'h0000_8000, 4'b0011); check_state("R3");
        host_write(5'd1, 32'h0000_8001, 4'b0001); check_state("R3");
        // R6 / R7: boundaries and random fetches
        fetch_check("R6", 16'd0);
        fetch_check("R6", 16'd31);
        fetch_check("R7", 16'd32);
        fetch_check("R7", 16'hFFFF);
        for (int i = 0; i < 60; i++) begin
            if (i % 2 == 0) fetch_check("R6", 16'($urandom % 32));
            else            fetch_check("R7", 16'(32 + $urandom % 65500));
        end
        // R3: release
        host_write(5'd1, 32'hABCD_8001, 4'b0011); check_state("R3");
        // R8: writes after release ignored
        for (int i = 0; i < 20; i++) host_write(5'($urandom % 16), $urandom, 4'b1111);
        host_write(5'd0, 32'h0000_0001, 4'b0001);
        check_state("R8");
        for (int i = 0; i < 8; i++) fetch_check("R8", 16'(i * 4));
        // R4: stray start-register writes do not revoke release
        host_write(5'd1, 32'h0, 4'b1111); check_state("R4");
        // R10 / R9: protection
        prot_write(8'hFE); check_state("R10");
        prot_write(8'h01); check_state("R9");
        for (int i = 0; i < 8; i++) fetch_check("R9", 16'(i * 4 + 3));
        prot_write(8'h00); check_state("R10");
        fetch_check("R10", 16'd0);
        // R10 / R1: only system reset restores the overlay
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_state("R1");
        fetch_check("R11 data", 16'd4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule